// File: doc/BRIEF.md
# Motor Power-Stage Enable Supervisor

This block decides whether the gate driver of a motor power stage may switch. It watches an emergency-stop input, two safety sensors that are each wired as a redundant pair of channels (a light curtain and a door switch), an over-temperature flag, a toggling liveness signal from a host processor with no real-time guarantees, a host stop request and an operator arm command. Power is allowed only while every one of these conditions is healthy and the operator has armed the stage with a fresh rising edge. When any condition is lost, the enable falls and the brake request rises in the same cycle, so the windings are shorted through the driver's brake input.

All inputs are treated as asynchronous and pass through two-flop synchronisers. Internally the block steps through four states: SAFE (idle), ARMED (everything healthy, waiting for the arm edge), RUN (enable high) and FAULT. A loss of health while running moves the block to FAULT and records every cause seen there in an 8-bit vector until an operator fault-clear returns it to SAFE. The host can force a stop but has no input that can hold one off.

Top module: `safety_enable_supervisor`

## Requirements
- R1: After reset `gate_enable` is 0, `brake_req` is 1 and `fault_cause` is 8'h00.
- R2: `gate_enable` rises only in the ARMED state when a rising edge of `arm_cmd` is seen, ARMED being reached only when every condition is healthy: no emergency stop, both channels of both sensors high, no discrepancy, heartbeat alive, no host stop, no over-temperature.
- R3: An arm rising edge seen before all conditions are healthy, or an arm input held high across a fault and its clear, does not set `gate_enable`; a new rising edge is required.
- R4: With SYNC_STAGES = 2, a condition loss while running clears `gate_enable` and sets `brake_req` on the third rising clock edge after the input changes, and not earlier than the second.
- R5: `estop_in` = 1 drops the enable regardless of the host inputs and sets `fault_cause` bit 0.
- R6: A sensor pair is unhealthy while either channel is 0 (curtain: cause bit 3, door: cause bit 4); when its channels disagree for DISC_CYCLES consecutive synchronised cycles a discrepancy is flagged (curtain: bit 1, door: bit 2) until they agree again.
- R7: The heartbeat is lost once no edge of `hb_toggle` has been seen for HB_TIMEOUT_CYC cycles, and is lost from reset until the first edge; loss sets cause bit 5.
- R8: `host_stop` = 1 drops the enable and sets cause bit 6; arm edges and heartbeat toggles during the stop cannot enable.
- R9: `over_temp` = 1 drops the enable and sets cause bit 7.
- R10: In FAULT, `fault_cause` accumulates every cause present and holds until `fault_clear` = 1, which returns the block to SAFE with `fault_cause` 8'h00 and enable still 0.
- R11: A loss of health in ARMED returns the block to SAFE without recording a cause; `fault_cause` stays 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| estop_in | input | 1 | Emergency stop, 1 = stop pressed |
| curtain_a | input | 1 | Light curtain channel A, 1 = clear |
| curtain_b | input | 1 | Light curtain channel B, 1 = clear |
| door_a | input | 1 | Door switch channel A, 1 = closed |
| door_b | input | 1 | Door switch channel B, 1 = closed |
| over_temp | input | 1 | Over-temperature flag, 1 = hot |
| hb_toggle | input | 1 | Host liveness level, must toggle |
| arm_cmd | input | 1 | Operator arm command, rising edge arms |
| host_stop | input | 1 | Host stop request, 1 = stop |
| fault_clear | input | 1 | Operator fault clear, 1 = clear |
| gate_enable | output | 1 | Gate-driver enable |
| brake_req | output | 1 | Brake request to the driver |
| fault_cause | output | 8 | Latched fault causes |

## Verification
The bench builds the supervisor with HB_TIMEOUT_CYC = 40 and DISC_CYCLES = 8 instead of millisecond-scale defaults, with a host toggle every 10 cycles. These short windows let a heartbeat loss and a channel discrepancy both develop and be latched in FAULT within a few dozen cycles, so timeout, discrepancy, accumulation and clear sequences all fit in one short run. SYNC_STAGES stays at 2 so the three-edge response latency is checked at its exact boundary.

// File: rtl/sis_pkg.sv
package sis_pkg;
  typedef enum logic [1:0] {
    ST_SAFE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_FAULT = 2'd3
  } sup_state_t;

  localparam int CAUSE_W      = 8;
  localparam int C_ESTOP      = 0;
  localparam int C_CURT_DISC  = 1;
  localparam int C_DOOR_DISC  = 2;
  localparam int C_CURT_OPEN  = 3;
  localparam int C_DOOR_OPEN  = 4;
  localparam int C_HB_LOST    = 5;
  localparam int C_HOST_STOP  = 6;
  localparam int C_OVER_TEMP  = 7;
endpackage

// File: rtl/sis_sync.sv
module sis_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= '0;
      else if (g == 0) stg[g] <= din;
      else stg[g] <= stg[(g == 0) ? 0 : g-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/sis_pair_check.sv
module sis_pair_check #(
  parameter int DISC_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic ch_a,
  input  logic ch_b,
  output logic open_o,
  output logic disc_o
);
  localparam int CW = $clog2(DISC_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DISC_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (ch_a == ch_b) cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + CW'(1);
  end

  assign open_o = !(ch_a && ch_b);
  assign disc_o = (cnt == LIMIT);

  // R6
  agree_clears_disc_chk: assert property (@(posedge clk) disable iff (rst)
    (ch_a == ch_b) |=> !disc_o);
endmodule

// File: rtl/sis_hb_monitor.sv
module sis_hb_monitor #(
  parameter int TIMEOUT = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic hb,
  output logic lost_o
);
  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

  logic          hb_q;
  logic          hb_edge;
  logic [CW-1:0] cnt;

  assign hb_edge = hb ^ hb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hb_q <= 1'b0;
      cnt  <= LIMIT;
    end else begin
      hb_q <= hb;
      if (hb_edge) cnt <= '0;
      else if (cnt != LIMIT) cnt <= cnt + CW'(1);
    end
  end

  assign lost_o = (cnt == LIMIT);

  // R7
  edge_revives_chk: assert property (@(posedge clk) disable iff (rst)
    hb_edge |=> !lost_o);
endmodule

// File: rtl/safety_enable_supervisor.sv
module safety_enable_supervisor
  import sis_pkg::*;
#(
  parameter int HB_TIMEOUT_CYC = 3750000,
  parameter int DISC_CYCLES    = 12500,
  parameter int SYNC_STAGES    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               estop_in,
  input  logic               curtain_a,
  input  logic               curtain_b,
  input  logic               door_a,
  input  logic               door_b,
  input  logic               over_temp,
  input  logic               hb_toggle,
  input  logic               arm_cmd,
  input  logic               host_stop,
  input  logic               fault_clear,
  output logic               gate_enable,
  output logic               brake_req,
  output logic [CAUSE_W-1:0] fault_cause
);
  localparam int NIN   = 10;
  localparam int NPAIR = 2;

  logic [NIN-1:0] raw_vec, s_vec;
  logic s_estop, s_ot, s_hb, s_arm, s_hstop, s_fclr;
  logic [NPAIR-1:0] pa, pb, pr_open, pr_disc;
  logic hb_lost;
  logic arm_q, arm_rise;
  logic [CAUSE_W-1:0] cause_now, cause_q;
  logic healthy;
  sup_state_t state, nst;

  assign raw_vec = {fault_clear, host_stop, arm_cmd, hb_toggle, over_temp,
                    door_b, door_a, curtain_b, curtain_a, estop_in};

  sis_sync #(.W(NIN), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .din(raw_vec), .dout(s_vec)
  );

  assign s_estop = s_vec[0];
  assign pa      = {s_vec[3], s_vec[1]};
  assign pb      = {s_vec[4], s_vec[2]};
  assign s_ot    = s_vec[5];
  assign s_hb    = s_vec[6];
  assign s_arm   = s_vec[7];
  assign s_hstop = s_vec[8];
  assign s_fclr  = s_vec[9];

  // pair 0 = light curtain, pair 1 = door switch
  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    sis_pair_check #(.DISC_CYCLES(DISC_CYCLES)) i_pair (
      .clk(clk), .rst(rst), .ch_a(pa[g]), .ch_b(pb[g]),
      .open_o(pr_open[g]), .disc_o(pr_disc[g])
    );
  end

  sis_hb_monitor #(.TIMEOUT(HB_TIMEOUT_CYC)) i_hb (
    .clk(clk), .rst(rst), .hb(s_hb), .lost_o(hb_lost)
  );

  always_ff @(posedge clk) begin
    if (rst) arm_q <= 1'b0;
    else     arm_q <= s_arm;
  end
  assign arm_rise = s_arm && !arm_q;

  always_comb begin
    cause_now              = '0;
    cause_now[C_ESTOP]     = s_estop;
    cause_now[C_CURT_DISC] = pr_disc[0];
    cause_now[C_DOOR_DISC] = pr_disc[1];
    cause_now[C_CURT_OPEN] = pr_open[0];
    cause_now[C_DOOR_OPEN] = pr_open[1];
    cause_now[C_HB_LOST]   = hb_lost;
    cause_now[C_HOST_STOP] = s_hstop;
    cause_now[C_OVER_TEMP] = s_ot;
  end
  assign healthy = (cause_now == '0);

  always_comb begin
    nst = state;
    unique case (state)
      ST_SAFE:  if (healthy) nst = ST_ARMED;
      ST_ARMED: if (!healthy) nst = ST_SAFE;
                else if (arm_rise) nst = ST_RUN;
      ST_RUN:   if (!healthy) nst = ST_FAULT;
      ST_FAULT: if (s_fclr) nst = ST_SAFE;
      default:  nst = ST_SAFE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_SAFE;
      gate_enable <= 1'b0;
      brake_req   <= 1'b1;
      cause_q     <= '0;
    end else begin
      state       <= nst;
      gate_enable <= (nst == ST_RUN);
      brake_req   <= (nst != ST_RUN);
      if (state == ST_FAULT && s_fclr) cause_q <= '0;
      else if (state == ST_FAULT || (state == ST_RUN && !healthy))
        cause_q <= cause_q | cause_now;
    end
  end

  assign fault_cause = cause_q;

  // R2
  enable_needs_arm_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_enable) |-> $past(arm_rise));
  // R4
  unhealthy_drops_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_enable && !healthy) |=> (!gate_enable && brake_req));
  // R5
  estop_drops_enable_chk: assert property (@(posedge clk) disable iff (rst)
    s_estop |=> !gate_enable);
  // R10
  fault_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAULT) |-> (cause_q != '0));
endmodule

// File: tb/test_safety_enable_supervisor.sv
module test_safety_enable_supervisor;
  localparam int HB_TO = 40;
  localparam int DISC  = 8;
  localparam int HBP   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic estop_in = 0, curtain_a = 0, curtain_b = 0, door_a = 0, door_b = 0;
  logic over_temp = 0, hb_toggle = 0, arm_cmd = 0, host_stop = 0, fault_clear = 0;
  logic gate_enable, brake_req;
  logic [7:0] fault_cause;

  int compared = 0, mismatched = 0;
  string cur_req = "R1";
  bit hb_run = 0;
  int hb_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  safety_enable_supervisor #(.HB_TIMEOUT_CYC(HB_TO), .DISC_CYCLES(DISC),
                             .SYNC_STAGES(2)) i_safety_enable_supervisor (
    .clk(clk), .rst(rst), .estop_in(estop_in), .curtain_a(curtain_a),
    .curtain_b(curtain_b), .door_a(door_a), .door_b(door_b),
    .over_temp(over_temp), .hb_toggle(hb_toggle), .arm_cmd(arm_cmd),
    .host_stop(host_stop), .fault_clear(fault_clear),
    .gate_enable(gate_enable), .brake_req(brake_req), .fault_cause(fault_cause)
  );

  // behavioural reference: delay line, integer timers, state number
  bit [9:0] q1, q2;
  int m_hb, m_cd, m_dd, m_st;
  bit m_hbq, m_armq, m_en;
  bit [7:0] m_cause;

  always @(posedge clk) begin
    bit [9:0] raw, s;
    bit [7:0] c;
    int nst;
    raw = {fault_clear, host_stop, arm_cmd, hb_toggle, over_temp,
           door_b, door_a, curtain_b, curtain_a, estop_in};
    if (rst) begin
      q1 = 0; q2 = 0; m_hb = HB_TO; m_cd = 0; m_dd = 0; m_st = 0;
      m_hbq = 0; m_armq = 0; m_en = 0; m_cause = 0;
    end else begin
      s = q2;
      c[0] = s[0];
      c[1] = (m_cd == DISC);
      c[2] = (m_dd == DISC);
      c[3] = !(s[1] && s[2]);
      c[4] = !(s[3] && s[4]);
      c[5] = (m_hb == HB_TO);
      c[6] = s[8];
      c[7] = s[5];
      nst = m_st;
      case (m_st)
        0: if (c == 0) nst = 1;
        1: if (c != 0) nst = 0; else if (s[7] && !m_armq) nst = 2;
        2: if (c != 0) nst = 3;
        default: if (s[9]) nst = 0;
      endcase
      if (m_st == 3 && s[9]) m_cause = 0;
      else if (m_st == 3 || (m_st == 2 && c != 0)) m_cause = m_cause | c;
      m_st = nst;
      m_en = (nst == 2);
      if (s[6] != m_hbq) m_hb = 0; else if (m_hb < HB_TO) m_hb++;
      if (s[1] == s[2]) m_cd = 0; else if (m_cd < DISC) m_cd++;
      if (s[3] == s[4]) m_dd = 0; else if (m_dd < DISC) m_dd++;
      m_hbq = s[6]; m_armq = s[7];
      q2 = q1; q1 = raw;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      compared++;
      if (gate_enable !== m_en || brake_req !== !m_en || fault_cause !== m_cause) begin
        mismatched++;
        $display("FAIL %s model compare: en=%0b brake=%0b cause=%02h expected en=%0b brake=%0b cause=%02h",
                 cur_req, gate_enable, brake_req, fault_cause, m_en, !m_en, m_cause);
      end
    end
  end

  always @(negedge clk) begin
    if (hb_run) begin
      hb_cnt++;
      if (hb_cnt == HBP) begin hb_toggle = ~hb_toggle; hb_cnt = 0; end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic arm_pulse();
    arm_cmd = 1; tick(3); arm_cmd = 0; tick(3);
  endtask

  task automatic do_clear();
    fault_clear = 1; tick(3); fault_clear = 0; tick(4);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        mismatched++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
      end
    end
  end

  initial begin
    tick(5);
    // R1 reset state
    chk("R1", "enable", {7'd0, gate_enable}, 8'h00);
    chk("R1", "brake", {7'd0, brake_req}, 8'h01);
    chk("R1", "cause", fault_cause, 8'h00);
    rst = 0;
    curtain_a = 1; curtain_b = 1; door_a = 1; door_b = 1;
    tick(6);
    // R3 arm edge with heartbeat not yet seen
    cur_req = "R3";
    arm_pulse();
    tick(4);
    chk("R3", "enable before health", {7'd0, gate_enable}, 8'h00);
    hb_run = 1;
    tick(25);
    chk("R3", "no enable without fresh edge", {7'd0, gate_enable}, 8'h00);
    // R2 arm in ARMED enables
    cur_req = "R2";
    arm_pulse();
    chk("R2", "enable after arm", {7'd0, gate_enable}, 8'h01);
    chk("R2", "brake off in run", {7'd0, brake_req}, 8'h00);
    // R4 latency and R6 curtain channel
    cur_req = "R4";
    curtain_a = 0;
    tick(2);
    chk("R4", "enable still high at 2 edges", {7'd0, gate_enable}, 8'h01);
    tick(1);
    chk("R4", "enable low at 3 edges", {7'd0, gate_enable}, 8'h00);
    chk("R4", "brake high at 3 edges", {7'd0, brake_req}, 8'h01);
    cur_req = "R6";
    chk("R6", "curtain open cause", fault_cause, 8'h08);
    tick(DISC + 4);
    chk("R6", "curtain discrepancy cause", fault_cause, 8'h0A);
    curtain_a = 1; tick(4);
    cur_req = "R10";
    chk("R10", "cause held until clear", fault_cause, 8'h0A);
    do_clear();
    chk("R10", "cause cleared", fault_cause, 8'h00);
    chk("R10", "enable off after clear", {7'd0, gate_enable}, 8'h00);
    arm_pulse();
    chk("R10", "re-arm after clear", {7'd0, gate_enable}, 8'h01);
    // R5 estop
    cur_req = "R5";
    estop_in = 1; tick(5);
    chk("R5", "estop enable", {7'd0, gate_enable}, 8'h00);
    chk("R5", "estop cause", fault_cause, 8'h01);
    estop_in = 0; tick(2); do_clear(); arm_pulse();
    chk("R5", "run after estop clear", {7'd0, gate_enable}, 8'h01);
    // R9 overtemp with arm held high, then R3 held arm
    cur_req = "R9";
    arm_cmd = 1; tick(3);
    over_temp = 1; tick(5);
    chk("R9", "overtemp enable", {7'd0, gate_enable}, 8'h00);
    chk("R9", "overtemp cause", fault_cause, 8'h80);
    over_temp = 0; tick(2); do_clear(); tick(10);
    cur_req = "R3";
    chk("R3", "held arm no enable", {7'd0, gate_enable}, 8'h00);
    arm_cmd = 0; tick(3); arm_pulse();
    chk("R3", "fresh edge enables", {7'd0, gate_enable}, 8'h01);
    // R8 host stop cannot be vetoed
    cur_req = "R8";
    host_stop = 1; tick(5);
    chk("R8", "host stop enable", {7'd0, gate_enable}, 8'h00);
    arm_pulse();
    chk("R8", "arm during stop", {7'd0, gate_enable}, 8'h00);
    chk("R8", "host stop cause", fault_cause, 8'h40);
    host_stop = 0; tick(2); do_clear(); arm_pulse();
    // R7 heartbeat timeout
    cur_req = "R7";
    hb_run = 0; tick(HB_TO + 8);
    chk("R7", "heartbeat lost enable", {7'd0, gate_enable}, 8'h00);
    chk("R7", "heartbeat lost cause", fault_cause, 8'h20);
    hb_run = 1; tick(15); do_clear(); arm_pulse();
    chk("R7", "run after heartbeat back", {7'd0, gate_enable}, 8'h01);
    // R11 loss in ARMED
    cur_req = "R11";
    host_stop = 1; tick(5); do_clear(); host_stop = 0; tick(6);
    door_a = 0; tick(6);
    chk("R11", "armed loss no cause", fault_cause, 8'h00);
    chk("R11", "armed loss enable", {7'd0, gate_enable}, 8'h00);
    door_a = 1; tick(6); arm_pulse();
    chk("R11", "enable after door back", {7'd0, gate_enable}, 8'h01);
    tick(5);
    finish_run();
  end
endmodule